// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds two 32-bit binary floating-point words. Each word has a sign in bit 31, a biased exponent in bits 30:23 (bias 127) and a fraction in bits 22:0. A normal word has the value (-1)^sign × (1 + fraction) × 2^(exponent − 127). An optional subtract control negates the second operand before the add. The result uses the same layout.

The datapath runs through three registered stages. The first stage unpacks the operands, orders them by magnitude and aligns the smaller one. The second adds or subtracts the significands and counts leading zeros. The third normalizes, checks the exponent range, rounds to nearest with ties to even, and renormalizes when rounding carries out.

Subnormal operands are treated as signed zeros. Infinities and NaNs follow fixed rules. A one-bit valid travels with each operation. A new operation may enter on every cycle and there is no stall.

Top module: `fp32_adder`

## Requirements
- R1: When `inValid` is sampled high at a rising edge, `outValid` is high and `result` holds that operation's value after exactly three rising edges. `outValid` is low at every other time. During reset, `outValid` and `result` are both 0.
- R2: For two finite normal operands, the result equals the exact sum rounded once to 24 significant bits, to nearest with ties to the even significand. This holds however far apart the exponents are.
- R3: With `subOp` high, the block returns `opA` minus `opB`, computed by inverting bit 31 of `opB`. When two nonzero finite operands cancel exactly, the result is +0 (0x00000000).
- R4: After a carry out of the significand add, the block shifts right and raises the exponent by one. After a cancellation, it shifts left and lowers the exponent by the shift. For example, 1.5 + 1.5 gives 0x40400000, and 1.0 − 0x3F7FFFFF gives 0x33800000.
- R5: If rounding carries out of the significand, the result is renormalized to 1.0 × 2^(e+1). For example, 0x3FFFFFFF + 0x33800000 gives 0x40000000.
- R6: If the rounded exponent reaches 255 or more, the result is an infinity with the result's sign (0x7F800000 or 0xFF800000).
- R7: Range is checked on the normalized exponent before rounding. If that exponent is 0 or below, the result is a zero that keeps the result's sign. `result` never carries exponent 0 with a nonzero fraction.
- R8: An operand with exponent field 0 is treated as a zero of its own sign, whatever its fraction.
- R9: If either operand has exponent 255 with a nonzero fraction, the result is 0x7FC00000. The sum of two opposite-signed infinities (after any `subOp` negation) is also 0x7FC00000.
- R10: An infinity plus a finite value, or plus an infinity of the same sign, returns that infinity.
- R11: When both operands are zero, the result is −0 (0x80000000) only if both effective signs are negative. Otherwise it is +0.
- R12: 0x40200000 (1.010b × 2^1) plus 0x41400000 (1.100b × 2^3) gives 0x41680000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands and `subOp` are valid this cycle |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| subOp | input | 1 | 1: compute opA − opB; 0: opA + opB |
| outValid | output | 1 | `result` holds a finished operation |
| result | output | 32 | Sum or difference word |

## Verification
The assertions assume that `inValid` is a known 0 while reset is held. They also assume that the operand words are fully defined whenever `inValid` is high, because the ordering check on the aligned significands and the output encoding checks read values loaded under that strobe. The bench keeps reset low for several cycles with `inValid` at 0, and drives only complete 32-bit words. The random stimulus draws exponents near each other so that cancellation and alignment get heavy use. It also mixes in zeros, subnormals, infinities and NaNs at low rates, and inserts idle cycles between operations.

// File: rtl/fp32_adder_pkg.sv
package fp32_adder_pkg;
  parameter int EXP_W  = 8;
  parameter int FRAC_W = 23;
  parameter int STAGES = 3;

  localparam int WORD_W   = 1 + EXP_W + FRAC_W;
  localparam int SIG_W    = FRAC_W + 1;        // with hidden one
  localparam int EXT_W    = SIG_W + 3;         // guard, round, sticky
  localparam int SUM_W    = EXT_W + 1;         // carry out
  localparam int SHAMT_W  = $clog2(EXT_W + 1);
  localparam int EXPS_W   = EXP_W + 2;         // signed working exponent
  localparam int EXP_TOP  = (1 << EXP_W) - 1;

  localparam logic [EXP_W-1:0]  EXP_ONES  = '1;
  localparam logic [EXP_W-1:0]  EXT_CLAMP = EXP_W'(EXT_W);
  localparam logic [FRAC_W-1:0] QNAN_FRAC = {1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [WORD_W-1:0] QNAN_WORD = {1'b0, EXP_ONES, QNAN_FRAC};

  typedef struct packed {
    logic ldUnpack;
    logic ldAdd;
    logic ldRound;
  } stageStb_t;
endpackage

// File: rtl/fp32_adder_lzc.sv
module fp32_adder_lzc #(
  parameter int W  = 27,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);
  always_comb begin
    count = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) count = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fp32_adder_shr.sv
module fp32_adder_shr #(
  parameter int IN_W  = 24,
  parameter int OUT_W = 27,
  parameter int SH_W  = 5
) (
  input  logic [IN_W-1:0]  sigIn,
  input  logic [SH_W-1:0]  shamt,
  output logic [OUT_W-1:0] aligned
);
  localparam int WIDE_W = IN_W + OUT_W;

  logic [WIDE_W-1:0] wide;
  logic [OUT_W-1:0]  hiPart;
  logic [IN_W-1:0]   loPart;

  always_comb begin
    wide    = {sigIn, {OUT_W{1'b0}}} >> shamt;
    hiPart  = wide[WIDE_W-1:IN_W];
    loPart  = wide[IN_W-1:0];
    aligned = {hiPart[OUT_W-1:1], hiPart[0] | (|loPart)};
  end
endmodule

// File: rtl/fp32_adder_ctrl.sv
module fp32_adder_ctrl
  import fp32_adder_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output stageStb_t stb,
  output logic      outValid
);
  logic [STAGES-1:0] vPipe;

  always_ff @(posedge clk) begin
    if (!rstN) vPipe <= '0;
    else       vPipe <= {vPipe[STAGES-2:0], inValid};
  end

  always_comb begin
    stb.ldUnpack = inValid;
    stb.ldAdd    = vPipe[0];
    stb.ldRound  = vPipe[1];
    outValid     = vPipe[STAGES-1];
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ##2 outValid); // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(stb.ldRound)); // R1
endmodule

// File: rtl/fp32_adder_dp.sv
module fp32_adder_dp
  import fp32_adder_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  stageStb_t         stb,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              subOp,
  output logic [WORD_W-1:0] result
);
  // ---------------- stage 1: unpack, order, align ----------------
  logic              aSign, bSign, aZero, bZero, aInf, bInf, aNan, bNan;
  logic [EXP_W-1:0]  aExp, bExp;
  logic [FRAC_W-1:0] aFrac, bFrac;
  logic [WORD_W-2:0] magA, magB;
  logic              bigIsB, bigSign, bigZero, smallZero;
  logic [EXP_W-1:0]  bigExp, smallExp, expDiff;
  logic [FRAC_W-1:0] bigFrac, smallFrac;
  logic [SIG_W-1:0]  smallSig;
  logic [SHAMT_W-1:0] alignAmt;
  logic [EXT_W-1:0]  alignedSmall;
  logic              specNext;
  logic [WORD_W-1:0] specWordNext;

  always_comb begin
    aSign = opA[WORD_W-1];
    bSign = opB[WORD_W-1] ^ subOp;
    aExp  = opA[WORD_W-2:FRAC_W];
    bExp  = opB[WORD_W-2:FRAC_W];
    aFrac = opA[FRAC_W-1:0];
    bFrac = opB[FRAC_W-1:0];
    aZero = (aExp == '0);
    bZero = (bExp == '0);
    aInf  = (aExp == EXP_ONES) && (aFrac == '0);
    bInf  = (bExp == EXP_ONES) && (bFrac == '0);
    aNan  = (aExp == EXP_ONES) && (aFrac != '0);
    bNan  = (bExp == EXP_ONES) && (bFrac != '0);
    magA  = aZero ? '0 : opA[WORD_W-2:0];
    magB  = bZero ? '0 : opB[WORD_W-2:0];
    bigIsB    = (magB > magA);
    bigSign   = bigIsB ? bSign : aSign;
    bigExp    = bigIsB ? bExp  : aExp;
    bigFrac   = bigIsB ? bFrac : aFrac;
    bigZero   = bigIsB ? bZero : aZero;
    smallExp  = bigIsB ? aExp  : bExp;
    smallFrac = bigIsB ? aFrac : bFrac;
    smallZero = bigIsB ? aZero : bZero;
    smallSig  = smallZero ? '0 : {1'b1, smallFrac};
    expDiff   = bigExp - smallExp;
    alignAmt  = (expDiff > EXT_CLAMP) ? SHAMT_W'(EXT_W) : expDiff[SHAMT_W-1:0];
    specNext  = aNan | bNan | aInf | bInf;
    if (aNan || bNan || (aInf && bInf && (aSign != bSign)))
      specWordNext = QNAN_WORD;
    else
      specWordNext = {aInf ? aSign : bSign, EXP_ONES, {FRAC_W{1'b0}}};
  end

  fp32_adder_shr #(.IN_W(SIG_W), .OUT_W(EXT_W), .SH_W(SHAMT_W)) u_align (
    .sigIn   (smallSig),
    .shamt   (alignAmt),
    .aligned (alignedSmall)
  );

  logic              s1Sign, s1Sub, s1Spec;
  logic [EXP_W-1:0]  s1Exp;
  logic [EXT_W-1:0]  s1Big, s1Small;
  logic [WORD_W-1:0] s1SpecWord;

  always_ff @(posedge clk) begin
    if (stb.ldUnpack) begin
      s1Sign     <= bigSign;
      s1Sub      <= aSign ^ bSign;
      s1Spec     <= specNext;
      s1SpecWord <= specWordNext;
      s1Exp      <= bigExp;
      s1Big      <= bigZero ? '0 : {1'b1, bigFrac, 3'b000};
      s1Small    <= alignedSmall;
    end
  end

  AST_ALIGN_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ldAdd && s1Sub) |-> (s1Big >= s1Small)); // R3

  // ---------------- stage 2: add / subtract, count zeros ----------------
  logic [SUM_W-1:0]   sumNext;
  logic [SHAMT_W-1:0] lzNext;

  always_comb begin
    if (s1Sub) sumNext = {1'b0, s1Big} - {1'b0, s1Small};
    else       sumNext = {1'b0, s1Big} + {1'b0, s1Small};
  end

  fp32_adder_lzc #(.W(EXT_W), .CW(SHAMT_W)) u_lzc (
    .vec   (sumNext[EXT_W-1:0]),
    .count (lzNext)
  );

  logic               s2Sign, s2Sub, s2Spec;
  logic [EXP_W-1:0]   s2Exp;
  logic [SUM_W-1:0]   s2Sum;
  logic [SHAMT_W-1:0] s2Lz;
  logic [WORD_W-1:0]  s2SpecWord;

  always_ff @(posedge clk) begin
    if (stb.ldAdd) begin
      s2Sign     <= s1Sign;
      s2Sub      <= s1Sub;
      s2Spec     <= s1Spec;
      s2SpecWord <= s1SpecWord;
      s2Exp      <= s1Exp;
      s2Sum      <= sumNext;
      s2Lz       <= lzNext;
    end
  end

  // ---------------- stage 3: normalize, range, round, pack ----------------
  logic                     carryOut, roundUp, rCarry, sumZero, under, over;
  logic signed [EXPS_W-1:0] expBase, expAdj, expR;
  logic [EXT_W-1:0]         norm;
  logic [SIG_W-1:0]         mant, mantF;
  logic [SIG_W:0]           mantR;
  logic [WORD_W-1:0]        resNext;

  always_comb begin
    carryOut = s2Sum[EXT_W];
    expBase  = $signed({2'b00, s2Exp});
    if (carryOut) begin
      norm   = {s2Sum[SUM_W-1:2], |s2Sum[1:0]};
      expAdj = expBase + EXPS_W'(1);
    end else begin
      norm   = s2Sum[EXT_W-1:0] << s2Lz;
      expAdj = expBase - $signed({{(EXPS_W-SHAMT_W){1'b0}}, s2Lz});
    end
    mant    = norm[EXT_W-1:3];
    roundUp = norm[2] & (norm[1] | norm[0] | mant[0]);
    mantR   = {1'b0, mant} + {{SIG_W{1'b0}}, roundUp};
    rCarry  = mantR[SIG_W];
    mantF   = rCarry ? mantR[SIG_W:1] : mantR[SIG_W-1:0];
    expR    = expAdj + $signed({{(EXPS_W-1){1'b0}}, rCarry});
    sumZero = (s2Sum == '0);
    under   = (expAdj <= 0);
    over    = (expR >= $signed(EXPS_W'(EXP_TOP)));
    if (s2Spec)
      resNext = s2SpecWord;
    else if (sumZero)
      resNext = {~s2Sub & s2Sign, {(WORD_W-1){1'b0}}};
    else if (under)
      resNext = {s2Sign, {(WORD_W-1){1'b0}}};
    else if (over)
      resNext = {s2Sign, EXP_ONES, {FRAC_W{1'b0}}};
    else
      resNext = {s2Sign, expR[EXP_W-1:0], mantF[FRAC_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN)            result <= '0;
    else if (stb.ldRound) result <= resNext;
  end

  AST_HIDDEN_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ldRound && !s2Spec && !sumZero && !under) |-> mantF[SIG_W-1]); // R4
  AST_NO_SUBNORMAL: assert property (@(posedge clk) disable iff (!rstN)
    (result[WORD_W-2:FRAC_W] == '0) |-> (result[FRAC_W-1:0] == '0)); // R7
  AST_SPECIAL_FRAC: assert property (@(posedge clk) disable iff (!rstN)
    (result[WORD_W-2:FRAC_W] == EXP_ONES) |->
      ((result[FRAC_W-1:0] == '0) || (result == QNAN_WORD))); // R9
endmodule

// File: rtl/fp32_adder.sv
module fp32_adder
  import fp32_adder_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic        subOp,
  output logic        outValid,
  output logic [31:0] result
);
  stageStb_t stb;

  fp32_adder_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .stb      (stb),
    .outValid (outValid)
  );

  fp32_adder_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .opA    (opA),
    .opB    (opB),
    .subOp  (subOp),
    .result (result)
  );
endmodule

// File: tb/fp32_adder_tb.sv
module fp32_adder_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        subOp = 1'b0;
  logic        outValid;
  logic [31:0] result;

  int checks = 0;
  int failures = 0;
  int cycle = 0;
  bit finished = 0;

  logic [31:0] expQ [16];
  int          cycQ [16];
  string       tagQ [16];
  int          wrP = 0;
  int          rdP = 0;

  fp32_adder u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .subOp(subOp), .outValid(outValid), .result(result)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] want);
    checks++;
    if (got !== want) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", tag, got, want);
    end
  endtask

  function automatic logic [31:0] refAdd(input logic [31:0] a, input logic [31:0] b, input logic sub);
    logic sa, sb, sh, sl, rs;
    int ea, eb, eh, el, d, p, k, e;
    logic [23:0] mh, ml;
    logic [79:0] x, y, s, mant, rem, half;
    sa = a[31]; sb = b[31] ^ sub;
    ea = int'(a[30:23]); eb = int'(b[30:23]);
    if ((ea == 255 && a[22:0] != 0) || (eb == 255 && b[22:0] != 0)) return 32'h7FC00000;
    if (ea == 255 && eb == 255) return (sa == sb) ? {sa, 8'hFF, 23'h0} : 32'h7FC00000;
    if (ea == 255) return {sa, 8'hFF, 23'h0};
    if (eb == 255) return {sb, 8'hFF, 23'h0};
    if (ea == 0 && eb == 0) return {sa & sb, 31'h0};
    if (ea == 0) return {sb, b[30:0]};
    if (eb == 0) return {sa, a[30:0]};
    if (ea >= eb) begin
      sh = sa; eh = ea; mh = {1'b1, a[22:0]}; sl = sb; el = eb; ml = {1'b1, b[22:0]};
    end else begin
      sh = sb; eh = eb; mh = {1'b1, b[22:0]}; sl = sa; el = ea; ml = {1'b1, a[22:0]};
    end
    d = eh - el;
    if (d > 40) return {sh, 8'(eh), mh[22:0]};
    x = 80'(mh) << d; y = 80'(ml);
    if (sh == sl) begin s = x + y; rs = sh; end
    else if (x > y) begin s = x - y; rs = sh; end
    else if (y > x) begin s = y - x; rs = sl; end
    else return 32'h0;
    p = 0;
    for (int i = 0; i < 80; i++) if (s[i]) p = i;
    e = el + p - 23;
    if (e <= 0) return {rs, 31'h0};
    if (p > 23) begin
      k = p - 23;
      mant = s >> k;
      rem  = s & ((80'd1 << k) - 80'd1);
      half = 80'd1 << (k - 1);
      if (rem > half || (rem == half && mant[0])) mant = mant + 80'd1;
      if (mant == (80'd1 << 24)) begin mant = mant >> 1; e = e + 1; end
    end else begin
      mant = s << (23 - p);
    end
    if (e >= 255) return {rs, 8'hFF, 23'h0};
    return {rs, 8'(e), mant[22:0]};
  endfunction

  task automatic service();
    if (outValid) begin
      if (wrP == rdP) begin
        checks++; failures++;
        $display("FAIL R1: actual outValid=1 expected outValid=0 (nothing pending)");
      end else begin
        check({tagQ[rdP % 16], " latency R1"}, 32'(cycle - cycQ[rdP % 16]), 32'd3);
        check(tagQ[rdP % 16], result, expQ[rdP % 16]);
        rdP++;
      end
    end else if (wrP != rdP && (cycle - cycQ[rdP % 16]) >= 3) begin
      checks++; failures++;
      $display("FAIL R1: actual outValid=0 expected outValid=1 (%s)", tagQ[rdP % 16]);
      rdP++;
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic s,
                       input logic [31:0] want, input string tag);
    @(negedge clk);
    service();
    opA = a; opB = b; subOp = s; inValid = 1'b1;
    expQ[wrP % 16] = want; cycQ[wrP % 16] = cycle; tagQ[wrP % 16] = tag;
    wrP++;
  endtask

  task automatic bubble();
    @(negedge clk);
    service();
    inValid = 1'b0;
  endtask

  function automatic logic [31:0] randOperand(input int ex);
    int r;
    r = int'($urandom % 100);
    if (r < 3) return {1'($urandom), 31'h0};
    if (r < 5) return {1'($urandom), 8'h00, 23'($urandom)};
    if (r < 7) return {1'($urandom), 8'hFF, 23'h0};
    if (r < 8) return {1'($urandom), 8'hFF, 23'($urandom) | 23'h1};
    return {1'($urandom), 8'(ex), 23'($urandom)};
  endfunction

  initial begin
    void'($urandom(32'd20230917));
    repeat (4) @(negedge clk);
    check("reset outValid R1", 32'(outValid), 32'd0);
    check("reset result R1", result, 32'h0);
    @(negedge clk); rstN = 1'b1;

    issue(32'h40200000, 32'h41400000, 1'b0, 32'h41680000, "worked example R12");
    issue(32'h3F800000, 32'h3F800000, 1'b1, 32'h00000000, "exact cancel via subOp R3");
    issue(32'hBF800000, 32'h3F800000, 1'b0, 32'h00000000, "exact cancel opposite signs R3");
    issue(32'h40400000, 32'h3F800000, 1'b1, 32'h40000000, "3-1 R3");
    issue(32'h3F800000, 32'h40400000, 1'b1, 32'hC0000000, "1-3 R3");
    issue(32'h3FC00000, 32'h3FC00000, 1'b0, 32'h40400000, "carry out R4");
    bubble();
    issue(32'h3F800000, 32'h3F7FFFFF, 1'b1, 32'h33800000, "deep cancel R4");
    issue(32'h3FFFFFFF, 32'h33800000, 1'b0, 32'h40000000, "round carry R5");
    issue(32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, "tie to even down R2");
    issue(32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, "tie to even up R2");
    issue(32'h3F800000, 32'h33800001, 1'b0, 32'h3F800001, "above half R2");
    issue(32'h3F800000, 32'h21800000, 1'b1, 32'h3F800000, "far sticky subtract R2");
    issue(32'h3F800000, 32'h21800000, 1'b0, 32'h3F800000, "far sticky add R2");
    issue(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, "overflow pos R6");
    issue(32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, 32'hFF800000, "overflow neg R6");
    issue(32'h00800001, 32'h00800000, 1'b1, 32'h00000000, "underflow pos R7");
    issue(32'h80800001, 32'h80800000, 1'b1, 32'h80000000, "underflow neg R7");
    issue(32'h00000001, 32'h3F800000, 1'b0, 32'h3F800000, "subnormal flushed R8");
    issue(32'h80000001, 32'h80000002, 1'b0, 32'h80000000, "two neg subnormals R8");
    issue(32'h80000005, 32'h00000000, 1'b0, 32'h00000000, "neg subnormal plus zero R8");
    issue(32'h7FC00001, 32'h3F800000, 1'b0, 32'h7FC00000, "nan operand R9");
    issue(32'h3F800000, 32'hFFFFFFFF, 1'b1, 32'h7FC00000, "nan second operand R9");
    issue(32'h7F800000, 32'h7F800000, 1'b1, 32'h7FC00000, "inf minus inf R9");
    issue(32'h7F800000, 32'hFF800000, 1'b0, 32'h7FC00000, "inf plus neg inf R9");
    issue(32'hFF800000, 32'h3F800000, 1'b0, 32'hFF800000, "neg inf plus one R10");
    issue(32'h3F800000, 32'h7F800000, 1'b1, 32'hFF800000, "one minus inf R10");
    issue(32'h7F800000, 32'h7F800000, 1'b0, 32'h7F800000, "inf plus inf R10");
    issue(32'h80000000, 32'h80000000, 1'b0, 32'h80000000, "neg zero sum R11");
    issue(32'h80000000, 32'h00000000, 1'b1, 32'h80000000, "neg zero minus zero R11");
    issue(32'h00000000, 32'h80000000, 1'b0, 32'h00000000, "mixed zeros R11");

    for (int n = 0; n < 4000; n++) begin
      int ea, eb;
      logic [31:0] a, b;
      logic s;
      if ($urandom % 5 == 0) bubble();
      ea = 1 + int'($urandom % 254);
      if ($urandom % 4 == 0) eb = 1 + int'($urandom % 254);
      else begin
        eb = ea + int'($urandom % 61) - 30;
        if (eb < 1) eb = 1;
        if (eb > 254) eb = 254;
      end
      a = randOperand(ea);
      b = randOperand(eb);
      s = 1'($urandom);
      issue(a, b, s, refAdd(a, b, s), "random R2");
    end

    repeat (6) bubble();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule